// File: doc/BRIEF.md
# SPD Image Generator

This block produces the 256-byte presence-detect image that describes a memory module of type SDR, DDR or DDR2 of a given capacity. A single-cycle `go` pulse starts a job. It samples a two-bit memory kind and the module capacity in megabytes. In one calculation cycle the block derives the bank count and the packed density byte from the capacity. It then streams every byte of the image into an external byte buffer, one write per clock, through a simple address/data/write-enable port.

The block sums the bytes as it emits them, so the checksum is known without reading the buffer back. It writes the checksum as the very last byte of the job and then raises `done`. A capacity that is not an exact power of two, or that is too small for the chosen kind, ends the job at once with `err` and `done` and without any write. `done` and `err` hold their values until the next accepted `go`.

Top module: `spd_image_gen`

## Requirements
- R1: While reset is held and after it is released, `wr_en`, `busy`, `done` and `err` are 0.
- R2: `mem_kind` encodes 0 = SDR, 1 = DDR, 2 = DDR2, and 3 is an error. Byte 2 of the image holds the kind code: 4 for SDR, 7 for DDR and 8 for DDR2.
- R3: The job fails with `err` = 1 and `done` = 1 and makes no write when any of these holds: `mem_kind` is 3, `size_mb` is not a power of two (zero included), or log2(`size_mb`) is below the kind minimum. The minimum is 2 for SDR, 5 for DDR and 7 for DDR2. The kind maximum is the minimum plus 7.
- R4: Bank count and working log2 size are derived as follows. Start with one bank. While log2 size is above the kind maximum and the count is below 8, decrement log2 size and double the count. If one bank remains and log2 size is above the minimum, decrement log2 size once more and use two banks. Byte 5 holds the count minus one for DDR2 and the count itself for SDR and DDR.
- R5: With raw = 1 << (working log2 size − 2), byte 31 holds the density byte. For SDR it is raw[7:0]. For DDR it is (raw & 0xF8) | ((raw >> 8) & 0x07). For DDR2 it is (raw & 0xE0) | ((raw >> 8) & 0x1F).
- R6: The fixed bytes are: byte 0 = 128, byte 1 = 8, byte 3 = 13, byte 4 = 10, byte 6 = 64. Every byte not named in R2, R4, R5, R6 or R7 is 0.
- R7: Byte 63 is the modulo-256 sum of bytes 0 to 62. It is the last byte written in a job.
- R8: A valid job makes exactly 256 writes on consecutive clocks, in the address order 0..62, then 64..255, then 63.
- R9: Edge 0 is the rising edge that samples `go`. A valid job writes on edges 2 to 257 and raises `done` on edge 258. A failing job raises `err` and `done` on edge 1.
- R10: `done` and `err` stay at their values until the next accepted `go`, which clears both on edge 0.
- R11: A `go` arriving while `busy` is 1 is ignored. The running job completes with its own inputs and its own number of writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse, accepted only when not busy |
| mem_kind | input | 2 | Memory kind select (0 SDR, 1 DDR, 2 DDR2, 3 invalid) |
| size_mb | input | SIZE_W | Module capacity in megabytes |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | 8 | Buffer byte address |
| wr_data | output | 8 | Buffer byte value |
| busy | output | 1 | A job is in progress |
| done | output | 1 | Job finished, held until next accepted go |
| err | output | 1 | Finished job had an invalid kind or capacity |

## Verification
Some properties are checked on every cycle by the assertions. Writes occur only while busy. The address walks the fixed order and wraps to byte 63 at the end. The checksum write is followed immediately by `done`. An error never coincides with a write. The bank count out of the geometry logic is always a single set bit. Only the bench scenarios can show that the byte values are correct: the bank split, the kind-dependent density packing, the checksum value, the exact latency, the holding of `done`, and the rejection of a second `go` mid-job. The bench compares each job's captured image against an image computed independently.

// File: rtl/spd_pkg.sv
package spd_pkg;

  localparam int IMG_BYTES = 256;
  localparam int ADDR_W    = $clog2(IMG_BYTES);
  localparam int CSUM_POS  = 63;

  typedef enum logic [1:0] {
    MK_SDR  = 2'd0,
    MK_DDR  = 2'd1,
    MK_DDR2 = 2'd2,
    MK_BAD  = 2'd3
  } mem_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_EMIT = 2'd2,
    ST_FIN  = 2'd3
  } gen_state_e;

  // Kind code stored in byte 2
  function automatic logic [7:0] kind_code(input logic [1:0] k);
    case (k)
      MK_SDR:  kind_code = 8'd4;
      MK_DDR:  kind_code = 8'd7;
      MK_DDR2: kind_code = 8'd8;
      default: kind_code = 8'd0;
    endcase
  endfunction

  function automatic logic [5:0] lg_floor(input logic [1:0] k);
    case (k)
      MK_SDR:  lg_floor = 6'd2;
      MK_DDR:  lg_floor = 6'd5;
      MK_DDR2: lg_floor = 6'd7;
      default: lg_floor = 6'd63;
    endcase
  endfunction

  function automatic logic [5:0] lg_ceil(input logic [1:0] k);
    lg_ceil = lg_floor(k) + 6'd7;
  endfunction

  function automatic logic [5:0] msb_index(input logic [31:0] v);
    logic [5:0] r;
    r = 6'd0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = 6'(i);
    end
    return r;
  endfunction

  function automatic logic single_bit(input logic [31:0] v);
    return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
  endfunction

  // Kind-dependent placement of the upper density bits
  function automatic logic [7:0] pack_density(input logic [1:0] k, input logic [31:0] raw);
    logic [7:0] lo, hi;
    lo = raw[7:0];
    hi = raw[15:8];
    case (k)
      MK_DDR2: pack_density = (lo & 8'hE0) | (hi & 8'h1F);
      MK_DDR:  pack_density = (lo & 8'hF8) | (hi & 8'h07);
      default: pack_density = lo;
    endcase
  endfunction

  // Emission order: 0..62, 64..255, then the checksum slot
  function automatic logic [ADDR_W-1:0] slot_to_addr(input logic [ADDR_W-1:0] slot);
    if (slot < ADDR_W'(CSUM_POS))
      slot_to_addr = slot;
    else if (slot == ADDR_W'(IMG_BYTES - 1))
      slot_to_addr = ADDR_W'(CSUM_POS);
    else
      slot_to_addr = slot + ADDR_W'(1);
  endfunction

endpackage

// File: rtl/spd_geom.sv
module spd_geom
  import spd_pkg::*;
#(
  parameter int SIZE_W    = 18,
  parameter int MAX_BANKS = 8,
  localparam int BANK_W   = $clog2(MAX_BANKS) + 1,
  localparam int STEPS    = $clog2(MAX_BANKS)
) (
  input  logic [1:0]        kind,
  input  logic [SIZE_W-1:0] size_mb,
  output logic              valid,
  output logic [BANK_W-1:0] banks,
  output logic [7:0]        density
);

  logic [31:0] size32;
  logic [5:0]  lg_in;
  logic [5:0]  lg_work;
  logic [5:0]  lo_lim;
  logic [5:0]  hi_lim;
  logic [31:0] raw;

  always_comb begin
    size32  = 32'(size_mb);
    lg_in   = msb_index(size32);
    lo_lim  = lg_floor(kind);
    hi_lim  = lg_ceil(kind);
    valid   = (kind != MK_BAD) && single_bit(size32) && (lg_in >= lo_lim);

    lg_work = lg_in;
    banks   = BANK_W'(1);
    for (int i = 0; i < STEPS; i++) begin
      if ((lg_work > hi_lim) && (banks < BANK_W'(MAX_BANKS))) begin
        lg_work = lg_work - 6'd1;
        banks   = banks << 1;
      end
    end
    if ((banks == BANK_W'(1)) && (lg_work > lo_lim)) begin
      lg_work = lg_work - 6'd1;
      banks   = BANK_W'(2);
    end

    raw     = (lg_work >= 6'd2) ? (32'd1 << (lg_work - 6'd2)) : 32'd0;
    density = pack_density(kind, raw);
  end

  always_comb begin
    if (valid === 1'b1)
      AST_BANKS_ONEHOT: assert ($onehot(banks)); // R4
  end

endmodule

// File: rtl/spd_seq.sv
module spd_seq
  import spd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);

  logic [ADDR_W-1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      slot_q <= '0;
    else if (clear)
      slot_q <= '0;
    else if (step)
      slot_q <= slot_q + ADDR_W'(1);
  end

  assign addr = slot_to_addr(slot_q);
  assign last = (slot_q == ADDR_W'(IMG_BYTES - 1));

  AST_SEQ_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (addr == '0)); // R8

endmodule

// File: rtl/spd_byte.sv
module spd_byte
  import spd_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        kind,
  input  logic [BANK_W-1:0] banks,
  input  logic [7:0]        density,
  input  logic [7:0]        csum,
  output logic [7:0]        value
);

  logic [7:0] bank_field;

  always_comb begin
    bank_field = (kind == MK_DDR2) ? 8'(banks) - 8'd1 : 8'(banks);
    case (addr)
      ADDR_W'(0):        value = 8'd128;
      ADDR_W'(1):        value = 8'd8;
      ADDR_W'(2):        value = kind_code(kind);
      ADDR_W'(3):        value = 8'd13;
      ADDR_W'(4):        value = 8'd10;
      ADDR_W'(5):        value = bank_field;
      ADDR_W'(6):        value = 8'd64;
      ADDR_W'(31):       value = density;
      ADDR_W'(CSUM_POS): value = csum;
      default:           value = 8'd0;
    endcase
  end

endmodule

// File: rtl/spd_image_gen.sv
module spd_image_gen
  import spd_pkg::*;
#(
  parameter int SIZE_W    = 18,
  parameter int MAX_BANKS = 8,
  localparam int BANK_W   = $clog2(MAX_BANKS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [1:0]        mem_kind,
  input  logic [SIZE_W-1:0] size_mb,
  output logic              wr_en,
  output logic [7:0]        wr_addr,
  output logic [7:0]        wr_data,
  output logic              busy,
  output logic              done,
  output logic              err
);

  gen_state_e        state_q;
  logic [1:0]        kind_q;
  logic [SIZE_W-1:0] size_q;
  logic [BANK_W-1:0] banks_q;
  logic [7:0]        dens_q;
  logic [7:0]        csum_q;

  logic              g_valid;
  logic [BANK_W-1:0] g_banks;
  logic [7:0]        g_dens;

  logic [ADDR_W-1:0] slot_addr;
  logic              slot_last;
  logic [7:0]        byte_val;

  // Named events for assertions
  logic go_accept;
  logic calc_fire;
  logic emit_fire;
  logic job_bad;

  assign go_accept = go && (state_q == ST_IDLE);
  assign calc_fire = (state_q == ST_CALC);
  assign emit_fire = (state_q == ST_EMIT);
  assign job_bad   = calc_fire && !g_valid;
  assign busy      = (state_q != ST_IDLE);

  spd_geom #(.SIZE_W(SIZE_W), .MAX_BANKS(MAX_BANKS)) u_geom (
    .kind    (kind_q),
    .size_mb (size_q),
    .valid   (g_valid),
    .banks   (g_banks),
    .density (g_dens)
  );

  spd_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (calc_fire),
    .step  (emit_fire),
    .addr  (slot_addr),
    .last  (slot_last)
  );

  spd_byte #(.BANK_W(BANK_W)) u_byte (
    .addr    (slot_addr),
    .kind    (kind_q),
    .banks   (banks_q),
    .density (dens_q),
    .csum    (csum_q),
    .value   (byte_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= MK_SDR;
      size_q  <= '0;
      banks_q <= '0;
      dens_q  <= '0;
      csum_q  <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (go_accept) begin
            kind_q  <= mem_kind;
            size_q  <= size_mb;
            done    <= 1'b0;
            err     <= 1'b0;
            state_q <= ST_CALC;
          end
        end
        ST_CALC: begin
          csum_q <= '0;
          if (job_bad) begin
            err     <= 1'b1;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            banks_q <= g_banks;
            dens_q  <= g_dens;
            state_q <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          wr_en   <= 1'b1;
          wr_addr <= slot_addr;
          wr_data <= byte_val;
          if (slot_addr != ADDR_W'(CSUM_POS))
            csum_q <= csum_q + byte_val;
          if (slot_last)
            state_q <= ST_FIN;
        end
        ST_FIN: begin
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_WR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!wr_en && !busy)); // R3

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done); // R3

  AST_ADDR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en) && ($past(wr_addr) != 8'd62) && ($past(wr_addr) != 8'd255))
      |-> (wr_addr == $past(wr_addr) + 8'd1)); // R8

  AST_SKIP_CSUM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == 8'd62)) |=> (wr_en && (wr_addr == 8'd64))); // R8

  AST_CSUM_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == 8'd63)) |=> (!wr_en && done)); // R7

  AST_DONE_AFTER_JOB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy)); // R9

endmodule

// File: tb/spd_image_gen_tb.sv
`timescale 1ns/1ps
module spd_image_gen_tb;

  localparam int SIZE_W = 18;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              go = 1'b0;
  logic [1:0]        mem_kind = 2'd0;
  logic [SIZE_W-1:0] size_mb = '0;
  logic              wr_en;
  logic [7:0]        wr_addr;
  logic [7:0]        wr_data;
  logic              busy;
  logic              done;
  logic              err;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] cap_img [256];
  int         cap_cnt [256];
  int         wcount;
  int         ord_err;
  int         last_addr;
  logic [7:0] exp_img [256];
  bit         exp_bad;

  always #5 clk = ~clk;

  spd_image_gen #(.SIZE_W(SIZE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .go(go), .mem_kind(mem_kind), .size_mb(size_mb),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .err(err)
  );

  // Capture writes away from the active edge; track the emission order
  always @(negedge clk) begin
    if (wr_en) begin
      int want;
      want = (wcount < 63) ? wcount : ((wcount < 255) ? wcount + 1 : 63);
      if (int'(wr_addr) != want) ord_err++;
      cap_img[wr_addr] = wr_data;
      cap_cnt[wr_addr]++;
      last_addr = int'(wr_addr);
      wcount++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent model of the image
  function automatic void build_expected(input int kind, input int size);
    int lg, lo, hi, nb, raw, d, code;
    for (int i = 0; i < 256; i++) exp_img[i] = 8'd0;
    case (kind)
      0: begin lo = 2; code = 4; end
      1: begin lo = 5; code = 7; end
      2: begin lo = 7; code = 8; end
      default: begin lo = 99; code = 0; end
    endcase
    hi = lo + 7;
    lg = 0;
    while ((64'd1 << (lg + 1)) <= 64'(size)) lg++;
    exp_bad = (kind == 3) || ($countones(size) != 1) || (lg < lo);
    if (exp_bad) return;
    nb = 1;
    while (lg > hi && nb < 8) begin lg--; nb = nb * 2; end
    if (nb == 1 && lg > lo) begin lg--; nb = 2; end
    raw = 1 << (lg - 2);
    if (kind == 2)      d = (raw % 256) / 32 * 32 + (raw / 256) % 32;
    else if (kind == 1) d = (raw % 256) / 8 * 8 + (raw / 256) % 8;
    else                d = raw % 256;
    exp_img[0] = 8'd128; exp_img[1] = 8'd8; exp_img[2] = 8'(code);
    exp_img[3] = 8'd13;  exp_img[4] = 8'd10;
    exp_img[5] = 8'((kind == 2) ? nb - 1 : nb);
    exp_img[6] = 8'd64;  exp_img[31] = 8'(d);
    begin
      int s;
      s = 0;
      for (int i = 0; i < 63; i++) s += int'(exp_img[i]);
      exp_img[63] = 8'(s % 256);
    end
  endfunction

  task automatic run_job(input int kind, input int size, input bit inject);
    int k;
    int seen;
    build_expected(kind, size);
    for (int i = 0; i < 256; i++) begin cap_img[i] = 8'hA5; cap_cnt[i] = 0; end
    wcount = 0; ord_err = 0; last_addr = -1;
    @(negedge clk);
    mem_kind = 2'(kind);
    size_mb  = SIZE_W'(size);
    go = 1'b1;
    k = 0;
    @(negedge clk);
    go = 1'b0;
    k = 1;
    // R10: previous done/err cleared on edge 0
    check(done == 1'b0 && err == 1'b0, "R10 done/err cleared by go", int'(done), 0);
    while (!done && k < 400) begin
      @(negedge clk);
      k++;
      if (inject && k == 50) begin
        mem_kind = 2'((kind + 1) % 3);
        size_mb  = SIZE_W'(64);
        go = 1'b1;
      end else begin
        go = 1'b0;
      end
    end
    go = 1'b0;
    check(k < 400, "R9 job completion (watchdog)", k, exp_bad ? 2 : 259);
    if (k >= 400) return;
    check(k == (exp_bad ? 2 : 259), "R9 latency to done", k, exp_bad ? 2 : 259);
    check(err == exp_bad, "R3 error flag", int'(err), int'(exp_bad));
    if (exp_bad) begin
      check(wcount == 0, "R3 no writes on error", wcount, 0);
    end else begin
      check(wcount == 256, inject ? "R11 write count with ignored go" : "R8 write count",
            wcount, 256);
      check(ord_err == 0, "R8 address order", ord_err, 0);
      check(last_addr == 63, "R7 checksum written last", last_addr, 63);
      seen = 0;
      for (int i = 0; i < 256; i++) if (cap_cnt[i] == 1) seen++;
      check(seen == 256, "R8 each address once", seen, 256);
      for (int i = 0; i < 256; i++) begin
        string req;
        case (i)
          2: req = "R2 kind code";
          5: req = "R4 bank field";
          31: req = "R5 density";
          63: req = "R7 checksum";
          default: req = "R6 fixed/zero byte";
        endcase
        check(cap_img[i] == exp_img[i], req, int'(cap_img[i]), int'(exp_img[i]));
      end
    end
    // R10: done and err hold with no further writes
    begin
      int wc0;
      bit e0;
      wc0 = wcount;
      e0 = err;
      repeat (5) @(negedge clk);
      check(done == 1'b1 && err == e0 && wcount == wc0, "R10 done held",
            int'(done), 1);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5bd1e995);
    wcount = 0; ord_err = 0; last_addr = -1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(wr_en == 0 && busy == 0 && done == 0 && err == 0, "R1 outputs during reset",
          int'({wr_en, busy, done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(wr_en == 0 && busy == 0 && done == 0 && err == 0, "R1 outputs after reset",
          int'({wr_en, busy, done, err}), 0);

    // Directed corners
    run_job(0, 32, 0);        // R4 SDR single bank forced split
    run_job(2, 256, 0);       // R4 DDR2 split, bank field minus one
    run_job(1, 8192, 0);      // R5 DDR packing of high bits
    run_job(2, 16384, 0);     // R5 DDR2 packing of high bits
    run_job(0, 4, 0);         // R4 at minimum: no split
    run_job(2, 131072, 0);    // R4 halving to 8 banks
    run_job(0, 131072, 0);    // R4 bank cap at 8 leaves large log2
    run_job(1, 16, 0);        // R3 below minimum
    run_job(0, 48, 0);        // R3 not a power of two
    run_job(1, 0, 0);         // R3 zero size
    run_job(3, 64, 0);        // R2 invalid kind
    run_job(1, 1024, 1);      // R11 go while busy ignored

    // Constrained random
    for (int n = 0; n < 20; n++) begin
      int kind, lg, size, lo;
      kind = int'($urandom_range(0, 3));
      lo   = (kind == 0) ? 2 : (kind == 1) ? 5 : 7;
      lg   = int'($urandom_range(0, 10)) + lo - 1;
      if (lg > 17) lg = 17;
      if (lg < 0) lg = 0;
      size = 1 << lg;
      if ($urandom_range(0, 4) == 0 && lg > 0)
        size = size | (1 << int'($urandom_range(0, lg - 1)));
      run_job(kind, size, $urandom_range(0, 5) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule